// File: doc/BRIEF.md
# MII PAUSE Frame Detector

This block watches the receive side of a 4-bit MII link, one nibble per clock with a data-valid qualifier. It finds the start of each frame by counting the preamble and locating the start-of-frame delimiter. It then joins nibble pairs into bytes and checks the bytes against the fixed header of a MAC control PAUSE frame.

When a frame carries that header and its 16-bit pause quantum arrives before data-valid drops, the block reports the quantum with a one-cycle strobe. The strobe comes on the cycle after the end of the frame. The frame check sequence and the padding are counted only. A MAC receive path instantiates this block beside its frame buffer, and the transmit-side pause logic consumes the strobe and the value.

Top module: `mii_pause_detect`

## Requirements
- R1: While reset is asserted, `pauseValid` is 0 and `pauseTimer` is 0.
- R2: The delimiter nibble 0xD starts a frame only after at least PRE_MIN (default 15) consecutive 0x5 nibbles with data-valid high. With fewer, the frame is ignored.
- R3: During the preamble search, any nibble other than 0x5 restarts the 0x5 count. A 0xD that arrives too early also restarts it, and so does data-valid low.
- R4: After the delimiter, each byte is built from two nibbles, the first received nibble being bits 3:0 and the second bits 7:4. Byte 0 is the first byte after the delimiter.
- R5: The frame is a PAUSE frame only if bytes 0 to 5 equal 01 80 C2 00 00 01, bytes 12 and 13 equal 88 08, and bytes 14 and 15 equal 00 01. A mismatch in any of these bytes suppresses the report.
- R6: Bytes 6 to 11 (sender address) and every byte after byte 17 (padding and check sequence) do not affect the result.
- R7: The reported value is byte 16 times 256 plus byte 17.
- R8: The report is a single-cycle `pauseValid` pulse on the cycle after the first clock edge that samples data-valid low at the end of a matching frame. `pauseTimer` takes the new value in that same cycle and holds it until the next report.
- R9: If data-valid drops before byte 17 is complete (including a trailing half byte), no report is made. A drop during the preamble produces nothing.
- R10: A new preamble may start in the cycle right after data-valid falls. The earlier frame is still reported, and the new frame is found and reported on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxNibble | input | 4 | Receive data nibble |
| rxValid | input | 1 | Receive data valid |
| pauseValid | output | 1 | One-cycle report strobe |
| pauseTimer | output | 16 | Last reported pause quantum |

## Verification
The end-of-frame report and the preamble search for the next frame can fall in the same cycle. This happens when data-valid is low for a single clock between two frames. The bench provokes it by raising data-valid with the first 0x5 nibble of the second frame in the cycle where the first report is due. It judges the result on three points: the first pulse and its value appear at that cycle, the second frame is still found and reported with its own value, and the pulse count over the pair is exactly two.

// File: rtl/mii_pause_pkg.sv
package mii_pause_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic startFrame;
    logic takeNib;
    logic endFrame;
  } ctrl_t;

  // status from datapath back
  typedef struct packed {
    logic hdrOk;
    logic gotTimer;
  } dp_stat_t;

  typedef enum logic {ST_HUNT, ST_BODY} rx_state_e;

  localparam int TMR_HI_IDX = 16;
  localparam int TMR_LO_IDX = 17;

  // byte positions whose value is fixed for a PAUSE frame
  function automatic logic isFixed(input int idx);
    return (idx < 6) || (idx >= 12 && idx < 16);
  endfunction

  function automatic logic [7:0] refByte(input int idx);
    case (idx)
      0:       return 8'h01;
      1:       return 8'h80;
      2:       return 8'hC2;
      5:       return 8'h01;
      12:      return 8'h88;
      13:      return 8'h08;
      15:      return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/mii_pause_ctrl.sv
module mii_pause_ctrl
  import mii_pause_pkg::*;
#(
  parameter int PRE_MIN = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] rxNibble,
  input  logic       rxValid,
  output ctrl_t      ctrlStb
);
  localparam int PRE_W = $clog2(PRE_MIN + 1);
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(PRE_MIN);

  rx_state_e        state;
  logic [PRE_W-1:0] preCnt;
  logic             sfdHit;

  assign sfdHit = rxValid && (rxNibble == 4'hD) && (preCnt >= PRE_TOP);

  always_comb begin
    ctrlStb = '0;
    case (state)
      ST_HUNT: ctrlStb.startFrame = sfdHit;
      ST_BODY: begin
        ctrlStb.takeNib  = rxValid;
        ctrlStb.endFrame = !rxValid;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_HUNT;
      preCnt <= '0;
    end else begin
      case (state)
        ST_HUNT: begin
          if (!rxValid) begin
            preCnt <= '0;
          end else if (rxNibble == 4'h5) begin
            if (preCnt != PRE_TOP) preCnt <= preCnt + 1'b1;
          end else if (sfdHit) begin
            preCnt <= '0;
            state  <= ST_BODY;
          end else begin
            preCnt <= '0;
          end
        end
        ST_BODY: begin
          if (!rxValid) state <= ST_HUNT;
        end
        default: state <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/mii_pause_dp.sv
module mii_pause_dp
  import mii_pause_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  rxNibble,
  input  ctrl_t       ctrlStb,
  output dp_stat_t    dpStat,
  output logic        pauseValid,
  output logic [15:0] pauseTimer
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [3:0]       loNib;
  logic             oddNib;
  logic [CNT_W-1:0] byteIdx;
  logic             hdrOk;
  logic             gotTimer;
  logic [15:0]      timerAcc;
  logic [7:0]       curByte;
  logic             report;

  assign curByte = {rxNibble, loNib};
  assign report  = ctrlStb.endFrame && hdrOk && gotTimer;
  assign dpStat  = '{hdrOk: hdrOk, gotTimer: gotTimer};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loNib    <= '0;
      oddNib   <= 1'b0;
      byteIdx  <= '0;
      hdrOk    <= 1'b0;
      gotTimer <= 1'b0;
      timerAcc <= '0;
    end else if (ctrlStb.startFrame) begin
      oddNib   <= 1'b0;
      byteIdx  <= '0;
      hdrOk    <= 1'b1;
      gotTimer <= 1'b0;
    end else if (ctrlStb.takeNib) begin
      if (!oddNib) begin
        loNib  <= rxNibble;
        oddNib <= 1'b1;
      end else begin
        oddNib <= 1'b0;
        if (byteIdx != CNT_MAX) byteIdx <= byteIdx + 1'b1;
        if (isFixed(int'(byteIdx)) && (curByte != refByte(int'(byteIdx))))
          hdrOk <= 1'b0;
        if (int'(byteIdx) == TMR_HI_IDX) timerAcc[15:8] <= curByte;
        if (int'(byteIdx) == TMR_LO_IDX) begin
          timerAcc[7:0] <= curByte;
          gotTimer      <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pauseValid <= 1'b0;
      pauseTimer <= '0;
    end else begin
      pauseValid <= report;
      if (report) pauseTimer <= timerAcc;
    end
  end
endmodule

// File: rtl/mii_pause_detect.sv
module mii_pause_detect
  import mii_pause_pkg::*;
#(
  parameter int PRE_MIN = 15,
  parameter int CNT_W   = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  rxNibble,
  input  logic        rxValid,
  output logic        pauseValid,
  output logic [15:0] pauseTimer
);
  ctrl_t    ctrlStb;
  dp_stat_t dpStat;

  mii_pause_ctrl #(.PRE_MIN(PRE_MIN)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .rxNibble (rxNibble),
    .rxValid  (rxValid),
    .ctrlStb  (ctrlStb)
  );

  mii_pause_dp #(.CNT_W(CNT_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .rxNibble   (rxNibble),
    .ctrlStb    (ctrlStb),
    .dpStat     (dpStat),
    .pauseValid (pauseValid),
    .pauseTimer (pauseTimer)
  );
endmodule

// File: rtl/mii_pause_detect_chk.sv
module mii_pause_detect_chk
  import mii_pause_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  rxNibble,
  input logic        rxValid,
  input logic        pauseValid,
  input logic [15:0] pauseTimer,
  input ctrl_t       ctrlStb,
  input dp_stat_t    dpStat
);
  // R1
  always @(negedge clk) begin
    if (!rstN) begin
      reset_state_chk: assert (!pauseValid && pauseTimer == 16'h0)
        else $error("reset state wrong");
    end
  end

  // R8
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    pauseValid |=> !pauseValid);

  // R8
  pulse_after_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    pauseValid |-> (!$past(rxValid) && $past(rxValid, 2)));

  // R8
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pauseTimer) |-> pauseValid);

  // R9
  timer_needed_chk: assert property (@(posedge clk) disable iff (!rstN)
    pauseValid |-> $past(dpStat.gotTimer));

  // R2
  sfd_nibble_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb.startFrame |-> (rxValid && rxNibble == 4'hD));
endmodule

bind mii_pause_detect mii_pause_detect_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .rxNibble   (rxNibble),
  .rxValid    (rxValid),
  .pauseValid (pauseValid),
  .pauseTimer (pauseTimer),
  .ctrlStb    (ctrlStb),
  .dpStat     (dpStat)
);

// File: tb/mii_pause_detect_tb_top.sv
module mii_pause_detect_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  rxNibble;
  logic        rxValid;
  logic        pauseValid;
  logic [15:0] pauseTimer;

  int checks = 0;
  int fails = 0;
  int pulseSeen = 0;
  bit finished = 1'b0;
  logic [15:0] lastTimer = 16'h0;
  logic [7:0] frm [0:63];

  always #2 clk = ~clk;

  mii_pause_detect dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .rxNibble   (rxNibble),
    .rxValid    (rxValid),
    .pauseValid (pauseValid),
    .pauseTimer (pauseTimer)
  );

  always @(posedge clk) if (rstN && pauseValid) pulseSeen++;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic buildPause(input logic [15:0] tmr);
    logic [7:0] hdr [0:17];
    hdr = '{8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h01,
            8'h00, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06,
            8'h88, 8'h08, 8'h00, 8'h01, tmr[15:8], tmr[7:0]};
    for (int i = 0; i < 64; i++)
      frm[i] = (i < 18) ? hdr[i] : ((i >= 60) ? 8'(8'h3C + i) : 8'h00);
  endtask

  task automatic nib(input logic [3:0] n);
    @(negedge clk);
    rxValid  = 1'b1;
    rxNibble = n;
  endtask

  task automatic sendFrame(input int preLen, input int nBytes, input bit extra);
    for (int i = 0; i < preLen; i++) nib(4'h5);
    nib(4'hD);
    for (int b = 0; b < nBytes; b++) begin
      nib(frm[b][3:0]);
      nib(frm[b][7:4]);
    end
    if (extra) nib(frm[nBytes][3:0]);
  endtask

  task automatic dropValid();
    @(negedge clk);
    rxValid  = 1'b0;
    rxNibble = 4'h0;
  endtask

  // closes the frame and judges the report
  task automatic judge(input int p0, input bit expPulse, input logic [15:0] expTmr,
                       input string req);
    dropValid();
    @(negedge clk);
    check(pauseValid == expPulse, req, "pulse", int'(pauseValid), int'(expPulse));
    if (expPulse) begin
      check(pauseTimer == expTmr, {req, "/R7"}, "timer", int'(pauseTimer), int'(expTmr));
      lastTimer = expTmr;
    end else begin
      check(pauseTimer == lastTimer, {req, "/R8 hold"}, "timer", int'(pauseTimer),
            int'(lastTimer));
    end
    @(negedge clk);
    check(!pauseValid, "R8 width", "pulse", int'(pauseValid), 0);
    repeat (2) @(negedge clk);
    check(pulseSeen - p0 == int'(expPulse), {req, " count"}, "pulses", pulseSeen - p0,
          int'(expPulse));
  endtask

  task automatic runFrame(input int preLen, input int nBytes, input bit extra,
                          input bit expPulse, input logic [15:0] expTmr, input string req);
    int p0;
    p0 = pulseSeen;
    sendFrame(preLen, nBytes, extra);
    judge(p0, expPulse, expTmr, req);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    rxValid = 1'b0;
    rxNibble = 4'h0;
    repeat (3) @(negedge clk);
    check(!pauseValid, "R1", "pulse", int'(pauseValid), 0);
    check(pauseTimer == 16'h0, "R1", "timer", int'(pauseTimer), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R4 R7: timer sweep, nibble order exercised by mixed-nibble values
    for (int k = 0; k < 18; k++) begin
      logic [15:0] t;
      t = (k == 16) ? 16'hFFFF : (k == 17) ? 16'h0000 : 16'(k * 16'h1357 + 16'h2468);
      buildPause(t);
      runFrame(15, 64, 1'b0, 1'b1, t, "R4/R7 sweep");
    end

    // R2: preamble length sweep
    for (int p = 1; p <= 20; p++) begin
      logic [15:0] t;
      t = 16'(16'h0100 + p);
      buildPause(t);
      runFrame(p, 64, 1'b0, p >= 15, t, "R2 preamble");
    end

    // R3: bad nibble and early delimiter restart the search
    buildPause(16'hBEEF);
    for (int i = 0; i < 10; i++) nib(4'h5);
    nib(4'h3);
    runFrame(15, 64, 1'b0, 1'b1, 16'hBEEF, "R3 restart ok");
    for (int i = 0; i < 10; i++) nib(4'h5);
    nib(4'h3);
    runFrame(5, 64, 1'b0, 1'b0, 16'h0, "R3 restart short");
    for (int i = 0; i < 10; i++) nib(4'h5);
    nib(4'hD);
    runFrame(5, 64, 1'b0, 1'b0, 16'h0, "R3 early sfd");
    for (int i = 0; i < 10; i++) nib(4'h5);
    dropValid();
    runFrame(5, 64, 1'b0, 1'b0, 16'h0, "R3 valid low");

    // R5 R6: corrupt one byte of the first sixteen
    for (int idx = 0; idx < 16; idx++) begin
      logic [15:0] t;
      bit fixedPos;
      t = 16'(16'h0A0B ^ idx);
      buildPause(t);
      frm[idx] = frm[idx] ^ 8'h10;
      fixedPos = (idx < 6) || (idx >= 12);
      runFrame(15, 64, 1'b0, !fixedPos, t, fixedPos ? "R5 mismatch" : "R6 source");
    end
    // R6: tail bytes altered
    buildPause(16'h7777);
    frm[30] = 8'h5D;
    frm[62] = 8'hFF;
    runFrame(15, 64, 1'b0, 1'b1, 16'h7777, "R6 tail");

    // R9: truncation sweep
    for (int n = 0; n <= 19; n++) begin
      buildPause(16'h4321);
      runFrame(15, n, 1'b0, n >= 18, 16'h4321, "R9 cut");
    end
    buildPause(16'h4321);
    runFrame(15, 17, 1'b1, 1'b0, 16'h0, "R9 half byte");
    for (int i = 0; i < 8; i++) nib(4'h5);
    judge(pulseSeen, 1'b0, 16'h0, "R9 preamble drop");

    // R10: one-cycle gap between two frames
    begin
      int p0;
      p0 = pulseSeen;
      buildPause(16'hA1B2);
      sendFrame(15, 64, 1'b0);
      dropValid();
      @(negedge clk);
      check(pauseValid, "R10 first", "pulse", int'(pauseValid), 1);
      check(pauseTimer == 16'hA1B2, "R10 first", "timer", int'(pauseTimer), 16'hA1B2);
      lastTimer = 16'hA1B2;
      rxValid = 1'b1;
      rxNibble = 4'h5;
      buildPause(16'h5C6D);
      sendFrame(14, 64, 1'b0);
      judge(p0 + 1, 1'b1, 16'h5C6D, "R10 second");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule